// File: doc/BRIEF.md
# Strap-Configured Shared Pin Function Selector

This block decides what each of five shared output pins carries. Every pin can present an internal chip-select strobe, one of the high address bits, or a software-controlled discrete level. The uppermost pin is a special case: in discrete mode it carries the bus E-clock instead of a port bit. Each pin has its own 2-bit function field. The five fields sit in one configuration register.

While reset is asserted, the register loads a default on every clock edge. The default is decoded from five data-bus levels sampled during reset. The value present on the edge where reset is released is the one kept. The decode is a priority chain read from the uppermost strap line downward. Each pin stays a chip-select only while every strap line from the top down to its own position reads high. Once a low line is seen, that pin and all pins below it become address outputs.

After reset, software may rewrite all five fields in one write. The pin outputs are combinational from the field register and the live source signals.

Top module: `pin_func_mux`

## Requirements
- R1: While reset is asserted, field k (bits [2k+1:2k], pin 0 lowest, strap line k paired with pin k) loads 2'b11 (chip-select) when strap lines N-1 down to k are all 1, and 2'b01 (address) otherwise.
- R2: When strap line N-1 is sampled 0, every pin is loaded with the address function, whatever the levels of the other strap lines.
- R3: When all strap lines are sampled 1, every pin is loaded with the chip-select function.
- R4: The reset default of a field is only ever 2'b01 or 2'b11.
- R5: After reset, the fields keep their strapped values while no write occurs, even if the strap lines change.
- R6: A write with the write enable high replaces all fields with the write data on the following clock edge. Reset has priority over a write.
- R7: Field value 2'b00 drives pin k from port data bit k, for every pin except the uppermost.
- R8: Field value 2'b00 on the uppermost pin drives that pin from the E-clock input.
- R9: Field value 2'b01 drives pin k from address bit k.
- R10: Field values 2'b11 and 2'b10 both drive pin k from chip-select strobe k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; strap lines are sampled while it is low |
| strap_i | input | 5 | Data-bus levels sampled during reset (bit 4 is the top of the chain) |
| cfg_we | input | 1 | Write enable for the function field register |
| cfg_wdata | input | 10 | New function fields, 2 bits per pin |
| port_data_i | input | 5 | Port data register value for discrete output |
| addr_i | input | 5 | Address bits routed to the pins (bit 0 is the lowest address bit) |
| cs_i | input | 5 | Internal chip-select strobes |
| eclk_i | input | 1 | Bus E-clock |
| pin_o | output | 5 | Shared pin values |

## Verification
The assertions check on every cycle that the value loaded at reset release has only address or chip-select fields, that the chip-select pins form an unbroken run from the top, that a low top strap leaves no chip-select, that the fields stay stable without a write, and that discrete mode drives the port bit or the E-clock. The bench scenarios are needed to show that each of the 32 strap patterns, including the don't-care lines, produces exactly the expected split between chip-select and address pins. They are also needed to show that a write after reset overrides the straps, and that the alias value 2'b10 selects the chip-select strobe.

// File: rtl/pin_func_pkg.sv
// Package: shared function-field encoding for the pin selector.
// Assumes a 2-bit field per pin; values 10 and 11 are both chip-select.
package pin_func_pkg;
    typedef enum logic [1:0] {
        FN_PORT     = 2'b00,
        FN_ADDR     = 2'b01,
        FN_CSEL_ALT = 2'b10,
        FN_CSEL     = 2'b11
    } pin_fn_e;
endpackage

// File: rtl/strap_chain_decode.sv
// Module: strap_chain_decode
// Turns the sampled strap lines into default function fields. Pin k is a
// chip-select only when all strap lines from the top down to k are high.
// Assumes strap line k pairs with pin k. The module is purely combinational.
module strap_chain_decode #(
    parameter int N_PINS = 5
) (
    input  logic [N_PINS-1:0]   strap_i,
    output logic [2*N_PINS-1:0] fields_o
);
    import pin_func_pkg::*;

    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        logic chain_high;
        // Purpose: AND of the strap lines from the top down to this pin.
        assign chain_high = &strap_i[N_PINS-1:k];
        // Purpose: select chip-select or address as the default for this pin.
        assign fields_o[2*k +: 2] = chain_high ? FN_CSEL : FN_ADDR;
    end
endmodule

// File: rtl/pin_output_select.sv
// Module: pin_output_select
// Routes one source per pin according to its function field. The top pin
// uses the E-clock in place of port data. Assumes the fields are already
// registered, so the outputs are combinational from stable state.
module pin_output_select #(
    parameter int N_PINS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*N_PINS-1:0] fields_i,
    input  logic [N_PINS-1:0]   port_data_i,
    input  logic [N_PINS-1:0]   addr_i,
    input  logic [N_PINS-1:0]   cs_i,
    input  logic                eclk_i,
    output logic [N_PINS-1:0]   pin_o
);
    import pin_func_pkg::*;

    localparam int TOP = N_PINS - 1;

    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        logic disc_src;
        logic [1:0] fn;
        assign fn = fields_i[2*k +: 2];

        if (k == TOP) begin : g_top
            // Purpose: the uppermost pin carries the E-clock in discrete mode.
            assign disc_src = eclk_i;

            // R8: discrete mode on the top pin shows the E-clock.
            p_eclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (fn == FN_PORT) |-> (pin_o[k] == eclk_i));
        end else begin : g_low
            // Purpose: other pins carry their port data bit in discrete mode.
            assign disc_src = port_data_i[k];

            // R7: discrete mode on a lower pin shows its port data bit.
            p_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (fn == FN_PORT) |-> (pin_o[k] == port_data_i[k]));
        end

        // Purpose: choose the pin source from the function field.
        always_comb begin
            case (fn)
                FN_PORT: pin_o[k] = disc_src;
                FN_ADDR: pin_o[k] = addr_i[k];
                default: pin_o[k] = cs_i[k];
            endcase
        end
    end
endmodule

// File: rtl/pin_func_mux.sv
// Module: pin_func_mux (top)
// Holds the per-pin function fields. While reset is low, the fields load the
// strap decode on every edge; after reset, they change only when written.
// Assumes a synchronous active-low reset and straps that are stable near
// the release edge.
module pin_func_mux #(
    parameter int N_PINS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PINS-1:0]   strap_i,
    input  logic                cfg_we,
    input  logic [2*N_PINS-1:0] cfg_wdata,
    input  logic [N_PINS-1:0]   port_data_i,
    input  logic [N_PINS-1:0]   addr_i,
    input  logic [N_PINS-1:0]   cs_i,
    input  logic                eclk_i,
    output logic [N_PINS-1:0]   pin_o
);
    localparam int FW = 2 * N_PINS;

    logic [FW-1:0] strap_fields;
    logic [FW-1:0] fn_q;

    strap_chain_decode #(.N_PINS(N_PINS)) i_decode (
        .strap_i  (strap_i),
        .fields_o (strap_fields)
    );

    // Purpose: field register, loaded from the straps in reset, then by writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      fn_q <= strap_fields;
        else if (cfg_we) fn_q <= cfg_wdata;
    end

    pin_output_select #(.N_PINS(N_PINS)) i_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .fields_i    (fn_q),
        .port_data_i (port_data_i),
        .addr_i      (addr_i),
        .cs_i        (cs_i),
        .eclk_i      (eclk_i),
        .pin_o       (pin_o)
    );

    // Purpose: split the field register into low and high bits for the checks.
    logic [N_PINS-1:0] fn_lsb, fn_msb;
    always_comb begin
        for (int k = 0; k < N_PINS; k++) begin
            fn_lsb[k] = fn_q[2*k];
            fn_msb[k] = fn_q[2*k+1];
        end
    end

    // R4: only the address or chip-select function is present after reset.
    p_reset_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&fn_lsb));

    // R1: the chip-select pins form an unbroken run from the top.
    p_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((fn_msb & ~(fn_msb >> 1) & ~(N_PINS'(1) << (N_PINS-1))) == '0));

    // R2: a low top strap leaves no chip-select pin.
    p_top_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !$past(strap_i[N_PINS-1])) |-> (fn_msb == '0));

    // R5: without a write, the fields hold after reset.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we)) |-> $stable(fn_q));
endmodule

// File: tb/test_pin_func_mux.sv
module test_pin_func_mux;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] strap_i = '1;
    logic         cfg_we = 1'b0;
    logic [2*N-1:0] cfg_wdata = '0;
    logic [N-1:0] port_data_i = '0;
    logic [N-1:0] addr_i = '0;
    logic [N-1:0] cs_i = '0;
    logic         eclk_i = 1'b0;
    logic [N-1:0] pin_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pin_func_mux #(.N_PINS(N)) i_pin_func_mux (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .port_data_i(port_data_i), .addr_i(addr_i),
        .cs_i(cs_i), .eclk_i(eclk_i), .pin_o(pin_o)
    );

    function automatic logic [2*N-1:0] strap_expect(input logic [N-1:0] s);
        logic [2*N-1:0] f;
        int run;
        run = 0;
        for (int i = N-1; i >= 0; i--) begin
            if (s[i] && run == N-1-i) run++;
        end
        for (int k = 0; k < N; k++)
            f[2*k +: 2] = (k >= N - run) ? 2'b11 : 2'b01;
        return f;
    endfunction

    function automatic logic [N-1:0] pins_expect(input logic [2*N-1:0] f);
        logic [N-1:0] p;
        for (int k = 0; k < N; k++) begin
            case (f[2*k +: 2])
                2'b00:   p[k] = (k == N-1) ? eclk_i : port_data_i[k];
                2'b01:   p[k] = addr_i[k];
                default: p[k] = cs_i[k];
            endcase
        end
        return p;
    endfunction

    task automatic check(input string req, input logic [N-1:0] exp);
        n_tests++;
        if (pin_o !== exp) begin
            n_fail++;
            $display("FAIL %s: pin_o=%b expected=%b", req, pin_o, exp);
        end
    endtask

    // Drive sources at negedge; check shortly after.
    task automatic drive_check(input string req, input logic [2*N-1:0] f,
                               input logic [N-1:0] pd, input logic [N-1:0] ad,
                               input logic [N-1:0] cs, input logic ec);
        @(negedge clk);
        port_data_i = pd; addr_i = ad; cs_i = cs; eclk_i = ec;
        #1;
        check(req, pins_expect(f));
    endtask

    task automatic strap_reset(input logic [N-1:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_i = s;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_fields(input logic [2*N-1:0] f);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = f;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: expired, expected run to finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2*N-1:0] f;
        // Reset state with all straps high: all chip-select (R3).
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive_check("R3 reset default", '1, 5'b10101, 5'b00000, 5'b11111, 1'b0);
        drive_check("R3 reset default inv", '1, 5'b01010, 5'b11111, 5'b00000, 1'b1);

        // R1/R2/R4: every strap pattern, including don't-care lines.
        for (int s = 0; s < 32; s++) begin
            strap_reset(N'(s));
            f = strap_expect(N'(s));
            drive_check($sformatf("R1 strap=%05b cs-high", s), f, 5'b00000, 5'b00000, 5'b11111, 1'b0);
            drive_check($sformatf("R1 strap=%05b addr-high", s), f, 5'b11111, 5'b11111, 5'b00000, 1'b1);
            if (s < 16)
                drive_check($sformatf("R2 strap=%05b all-addr", s), {N{2'b01}},
                            5'b01100, 5'b10110, 5'b01001, 1'b1);
            if (s == 31)
                drive_check("R3 all-high", {N{2'b11}}, 5'b01100, 5'b10110, 5'b01001, 1'b0);
        end

        // R5: straps changing after reset do not move the fields.
        strap_reset(5'b11011);
        f = strap_expect(5'b11011);
        @(negedge clk); strap_i = 5'b00000;
        repeat (3) @(negedge clk);
        drive_check("R5 hold after strap change", f, 5'b00000, 5'b00000, 5'b11111, 1'b0);
        drive_check("R5 hold inv", f, 5'b11111, 5'b11111, 5'b00000, 1'b1);

        // R6-R10: uniform field values, several source patterns.
        for (int m = 0; m < 4; m++) begin
            f = {N{2'(m)}};
            write_fields(f);
            for (int p = 0; p < 4; p++) begin
                string rq;
                rq = (m == 0) ? "R7/R8 discrete" : (m == 1) ? "R9 address" :
                     (m == 2) ? "R10 cs alias" : "R10 cs";
                drive_check($sformatf("%s R6 pat%0d", rq, p), f,
                            N'(5'b10110 ^ (p * 7)), N'(5'b01101 ^ (p * 5)),
                            N'(5'b11001 ^ (p * 3)), p[0]);
            end
        end

        // R8: top pin follows the E-clock both ways, port bit opposite.
        write_fields('0);
        drive_check("R8 eclk high", '0, 5'b01111, 5'b00000, 5'b00000, 1'b1);
        drive_check("R8 eclk low", '0, 5'b11111, 5'b11111, 5'b11111, 1'b0);

        // R6: mixed per-pin fields.
        f = {2'b00, 2'b01, 2'b10, 2'b11, 2'b00};
        write_fields(f);
        drive_check("R6 mixed a", f, 5'b10101, 5'b01010, 5'b11100, 1'b0);
        drive_check("R6 mixed b", f, 5'b01010, 5'b10101, 5'b00011, 1'b1);

        // R6: reset beats a simultaneous write.
        @(negedge clk);
        rst_n = 1'b0; strap_i = 5'b10111; cfg_we = 1'b1; cfg_wdata = '0;
        @(negedge clk);
        cfg_we = 1'b0; rst_n = 1'b1;
        drive_check("R6 reset priority", strap_expect(5'b10111), 5'b00000, 5'b00000, 5'b11111, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule